// File: doc/BRIEF.md
# Redundant Residue Single-Error Corrector

This block accepts one codeword of a redundant residue number system and returns the integer it carries. If one residue was corrupted in storage or transport, it also returns the repaired codeword. The code uses five pairwise coprime moduli built from one width parameter `N`. Three information moduli, 2^N-1, 2^N and 2^N+1, define the legitimate range M = (2^N-1)·2^N·(2^N+1). Two redundant moduli, 2^(2N)-3 and 2^(2N)+1, supply the check information. With N = 2 the moduli are 3, 4, 5, 13 and 17, and M = 60.

After a start pulse the block captures the five residues. A single shared mixed-radix rebuild unit then evaluates one configuration per clock cycle. The first configuration rebuilds the integer from all five residues. If that value is below M, the codeword is clean. Otherwise the five projections decide. Each projection leaves out one residue, rebuilds from the other four and tests the result against the legitimate range. When exactly one projection is legitimate, the residue it leaves out is the faulty one. The block then reports that position, returns the projected integer and rewrites every residue as that integer reduced by its modulus. When no projection or more than one projection is legitimate, the block flags the word as uncorrectable.

The latency is fixed, so a caller can plan on the result six clock edges after the edge that accepts the start.

Top module: `rrns_corrector`

## Requirements
- R1: Port `res1_i` carries the residue modulo 2^N-1, `res2_i` modulo 2^N, `res3_i` modulo 2^N+1, `res4_i` modulo 2^(2N)-3 and `res5_i` modulo 2^(2N)+1. The five residues of any integer below M decode back to that integer.
- R2: `start_i` is accepted on a rising clock edge while the block is idle. `valid_o` then rises exactly six rising edges later and stays high for one cycle only.
- R3: If the five-residue rebuild is below M, the block returns `err_o`=0, `uncorr_o`=0, `err_idx_o`=0 and `value_o` equal to the rebuilt integer.
- R4: If exactly one residue differs from the codeword of some X below M, the block returns `err_o`=1, `uncorr_o`=0 and `err_idx_o` equal to the number of the faulty residue port (1 to 5).
- R5: After a single-residue correction, `value_o` equals the original integer X.
- R6: When `uncorr_o`=0, each of `fix1_o` to `fix5_o` equals `value_o` reduced by its modulus, which restores the codeword.
- R7: If the five-residue rebuild is not legitimate and the number of legitimate projections is other than one, the block returns `uncorr_o`=1, `err_o`=0, `err_idx_o`=0 and `value_o`=0. In that case the fix outputs echo the received residues.
- R8: After reset, `valid_o`, `err_o`, `uncorr_o`, `err_idx_o` and `value_o` are all 0.
- R9: `err_o` and `uncorr_o` are never both high. `value_o` is below M whenever a result is not uncorrectable.
- R10: A start pulse, and any change on the residue inputs, while a word is being processed has no effect. The result belongs to the word captured at the accepted start, and no extra `valid_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin processing the word on the residue inputs |
| res1_i | input | N | Residue modulo 2^N-1 |
| res2_i | input | N | Residue modulo 2^N |
| res3_i | input | N+1 | Residue modulo 2^N+1 |
| res4_i | input | 2N | Residue modulo 2^(2N)-3 |
| res5_i | input | 2N+1 | Residue modulo 2^(2N)+1 |
| valid_o | output | 1 | One-cycle result strobe |
| value_o | output | clog2(M) | Decoded integer |
| fix1_o | output | N | Repaired residue modulo 2^N-1 |
| fix2_o | output | N | Repaired residue modulo 2^N |
| fix3_o | output | N+1 | Repaired residue modulo 2^N+1 |
| fix4_o | output | 2N | Repaired residue modulo 2^(2N)-3 |
| fix5_o | output | 2N+1 | Repaired residue modulo 2^(2N)+1 |
| err_o | output | 1 | One residue was found faulty and repaired |
| err_idx_o | output | 3 | Number of the faulty residue, 0 when none |
| uncorr_o | output | 1 | Word cannot be repaired |

## Verification
The assertions check several properties on every cycle. They check the start-to-valid latency and that the strobe lasts one cycle. They check that the error and uncorrectable flags are exclusive, that the error index is in range and is zero when no error is reported, and that any value not flagged uncorrectable lies in the legitimate range. Other behaviours can only be shown by the bench's scenarios, because they require a model of the code. These are whether the decoded integer is the right one, whether the located residue is the corrupted one, and whether the repaired residues match the codeword. The bench covers every integer below M with every possible single-residue corruption, plus random double corruptions and an attempt to restart while the block is busy.

// File: rtl/rrns_pkg.sv
package rrns_pkg;

  localparam int NUM_RES = 5;
  localparam int NUM_CFG = 6;  // full rebuild + one projection per residue
  localparam int LAT     = 6;

  function automatic longint unsigned modulus(int n, int i);
    longint unsigned one = 64'd1;
    case (i)
      0:       return (one << n) - 1;
      1:       return (one << n);
      2:       return (one << n) + 1;
      3:       return (one << (2 * n)) - 3;
      default: return (one << (2 * n)) + 1;
    endcase
  endfunction

  function automatic longint unsigned legit_range(int n);
    return modulus(n, 0) * modulus(n, 1) * modulus(n, 2);
  endfunction

  function automatic int legit_width(int n);
    return $clog2(legit_range(n));
  endfunction

  // product of the moduli ahead of position j that config s keeps
  function automatic longint unsigned prod_before(int n, int s, int j);
    longint unsigned p = 64'd1;
    for (int k = 0; k < j; k++)
      if (k != s - 1) p = p * modulus(n, k);
    return p;
  endfunction

  function automatic longint unsigned inv_mod(longint unsigned a, longint unsigned m);
    for (longint unsigned v = 1; v < m; v++)
      if (((a * v) % m) == 1) return v;
    return 64'd1;
  endfunction

  function automatic longint unsigned inv_before(int n, int s, int j);
    longint unsigned m = modulus(n, j);
    return inv_mod(prod_before(n, s, j) % m, m);
  endfunction

endpackage

// File: rtl/rrns_mrc.sv
// Shared mixed-radix rebuild; sel_i=0 keeps all residues, sel_i=k drops residue k.
module rrns_mrc #(
  parameter int N = 2,
  localparam int RW = 2 * N + 1,
  localparam int VW = rrns_pkg::legit_width(N)
) (
  input  logic [2:0]                          sel_i,
  input  logic [rrns_pkg::NUM_RES-1:0][RW-1:0] res_i,
  output logic [VW-1:0]                       value_o,
  output logic                                legit_o
);
  import rrns_pkg::*;

  localparam longint unsigned MLEG = legit_range(N);

  logic [63:0] mod_tab [NUM_RES];
  logic [63:0] pw_tab  [8][NUM_RES];
  logic [63:0] iv_tab  [8][NUM_RES];

  for (genvar j = 0; j < NUM_RES; j++) begin : g_mod
    localparam longint unsigned MJ = modulus(N, j);
    assign mod_tab[j] = 64'(MJ);
    for (genvar s = 0; s < 8; s++) begin : g_cfg
      localparam longint unsigned PW = prod_before(N, s, j);
      localparam longint unsigned IV = inv_before(N, s, j);
      assign pw_tab[s][j] = 64'(PW);
      assign iv_tab[s][j] = 64'(IV);
    end
  end

  logic [63:0] acc;

  always_comb begin
    logic [63:0] r, t, a, m;
    acc = '0;
    r = '0;
    t = '0;
    a = '0;
    m = '0;
    for (int j = 0; j < NUM_RES; j++) begin
      m = mod_tab[j];
      if (sel_i != 3'(j + 1)) begin
        r   = 64'(res_i[j]) % m;
        t   = (r + m - (acc % m)) % m;
        a   = (t * iv_tab[sel_i][j]) % m;
        acc = acc + a * pw_tab[sel_i][j];
      end
    end
  end

  assign value_o = VW'(acc);
  assign legit_o = (acc < 64'(MLEG));

endmodule

// File: rtl/rrns_seq.sv
// Steps the rebuild unit through all configurations and tallies legitimate projections.
module rrns_seq #(
  parameter int N = 2,
  localparam int VW = rrns_pkg::legit_width(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          legit_i,
  input  logic [VW-1:0] value_i,
  output logic          load_o,
  output logic [2:0]    sel_o,
  output logic          last_o,
  output logic          full_ok_o,
  output logic [VW-1:0] full_val_o,
  output logic [1:0]    hits_o,
  output logic [2:0]    hit_idx_o,
  output logic [VW-1:0] hit_val_o
);
  import rrns_pkg::*;

  localparam logic [2:0] LAST_SEL = 3'(NUM_CFG - 1);

  logic          busy_q;
  logic [2:0]    sel_q;
  logic          full_ok_q;
  logic [VW-1:0] full_val_q;
  logic [1:0]    hits_q;
  logic [2:0]    idx_q;
  logic [VW-1:0] val_q;
  logic          cur_hit;

  assign load_o = !busy_q && start_i;
  assign sel_o  = sel_q;
  assign last_o = busy_q && (sel_q == LAST_SEL);

  assign cur_hit   = busy_q && (sel_q != 3'd0) && legit_i;
  assign hits_o    = cur_hit ? ((hits_q == 2'd2) ? 2'd2 : hits_q + 2'd1) : hits_q;
  assign hit_idx_o = cur_hit ? sel_q : idx_q;
  assign hit_val_o = cur_hit ? value_i : val_q;
  assign full_ok_o  = full_ok_q;
  assign full_val_o = full_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      sel_q      <= '0;
      full_ok_q  <= 1'b0;
      full_val_q <= '0;
      hits_q     <= '0;
      idx_q      <= '0;
      val_q      <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q    <= 1'b1;
        sel_q     <= '0;
        full_ok_q <= 1'b0;
        hits_q    <= '0;
        idx_q     <= '0;
        val_q     <= '0;
      end
    end else begin
      if (sel_q == 3'd0) begin
        full_ok_q  <= legit_i;
        full_val_q <= value_i;
      end
      hits_q <= hits_o;
      idx_q  <= hit_idx_o;
      val_q  <= hit_val_o;
      if (sel_q == LAST_SEL) begin
        busy_q <= 1'b0;
        sel_q  <= '0;
      end else begin
        sel_q <= sel_q + 3'd1;
      end
    end
  end

endmodule

// File: rtl/rrns_restore.sv
// Re-encodes the chosen integer, or echoes the received word when nothing can be trusted.
module rrns_restore #(
  parameter int N = 2,
  localparam int RW = 2 * N + 1,
  localparam int VW = rrns_pkg::legit_width(N)
) (
  input  logic [VW-1:0]                        value_i,
  input  logic                                 keep_i,
  input  logic [rrns_pkg::NUM_RES-1:0][RW-1:0] res_i,
  output logic [rrns_pkg::NUM_RES-1:0][RW-1:0] fix_o
);
  import rrns_pkg::*;

  for (genvar j = 0; j < NUM_RES; j++) begin : g_res
    localparam longint unsigned MJ = modulus(N, j);
    logic [RW-1:0] rem;
    assign rem      = RW'(64'(value_i) % 64'(MJ));
    assign fix_o[j] = keep_i ? res_i[j] : rem;
  end

endmodule

// File: rtl/rrns_corrector.sv
module rrns_corrector #(
  parameter int N = 2,
  localparam int RW = 2 * N + 1,
  localparam int VW = rrns_pkg::legit_width(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [N-1:0]    res1_i,
  input  logic [N-1:0]    res2_i,
  input  logic [N:0]      res3_i,
  input  logic [2*N-1:0]  res4_i,
  input  logic [2*N:0]    res5_i,
  output logic            valid_o,
  output logic [VW-1:0]   value_o,
  output logic [N-1:0]    fix1_o,
  output logic [N-1:0]    fix2_o,
  output logic [N:0]      fix3_o,
  output logic [2*N-1:0]  fix4_o,
  output logic [2*N:0]    fix5_o,
  output logic            err_o,
  output logic [2:0]      err_idx_o,
  output logic            uncorr_o
);
  import rrns_pkg::*;

  logic [NUM_RES-1:0][RW-1:0] res_in, res_q, fix_n, fix_q;
  logic          load, last, mrc_legit, full_ok, uncorr_n;
  logic [2:0]    sel, hit_idx;
  logic [1:0]    hits;
  logic [VW-1:0] mrc_val, full_val, hit_val, pick_val;

  assign res_in[0] = RW'(res1_i);
  assign res_in[1] = RW'(res2_i);
  assign res_in[2] = RW'(res3_i);
  assign res_in[3] = RW'(res4_i);
  assign res_in[4] = RW'(res5_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   res_q <= '0;
    else if (load) res_q <= res_in;
  end

  rrns_mrc #(.N(N)) i_mrc (
    .sel_i   (sel),
    .res_i   (res_q),
    .value_o (mrc_val),
    .legit_o (mrc_legit)
  );

  rrns_seq #(.N(N)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .legit_i    (mrc_legit),
    .value_i    (mrc_val),
    .load_o     (load),
    .sel_o      (sel),
    .last_o     (last),
    .full_ok_o  (full_ok),
    .full_val_o (full_val),
    .hits_o     (hits),
    .hit_idx_o  (hit_idx),
    .hit_val_o  (hit_val)
  );

  assign uncorr_n = !full_ok && (hits != 2'd1);
  assign pick_val = full_ok ? full_val : (uncorr_n ? '0 : hit_val);

  rrns_restore #(.N(N)) i_restore (
    .value_i (pick_val),
    .keep_i  (uncorr_n),
    .res_i   (res_q),
    .fix_o   (fix_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      value_o   <= '0;
      err_o     <= 1'b0;
      err_idx_o <= '0;
      uncorr_o  <= 1'b0;
      fix_q     <= '0;
    end else begin
      valid_o <= last;
      if (last) begin
        value_o   <= pick_val;
        fix_q     <= fix_n;
        uncorr_o  <= uncorr_n;
        err_o     <= !full_ok && !uncorr_n;
        err_idx_o <= (!full_ok && !uncorr_n) ? hit_idx : 3'd0;
      end
    end
  end

  assign fix1_o = N'(fix_q[0]);
  assign fix2_o = N'(fix_q[1]);
  assign fix3_o = (N+1)'(fix_q[2]);
  assign fix4_o = (2*N)'(fix_q[3]);
  assign fix5_o = fix_q[4];

endmodule

// File: rtl/rrns_corrector_chk.sv
module rrns_corrector_chk #(
  parameter int N = 2,
  localparam int VW = rrns_pkg::legit_width(N)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          valid_o,
  input logic [VW-1:0] value_o,
  input logic          err_o,
  input logic [2:0]    err_idx_o,
  input logic          uncorr_o
);
  import rrns_pkg::*;

  localparam longint unsigned MLEG = legit_range(N);
  localparam int CW = $clog2(LAT + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt <= '0;
    else if (cnt == '0 || cnt == CW'(LAT + 1))    cnt <= start_i ? CW'(1) : '0;
    else                                          cnt <= cnt + CW'(1);
  end

  a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (cnt == CW'(LAT + 1)));

  a_r2_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(err_o && uncorr_o));

  a_r4_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> (err_idx_o >= 3'd1 && err_idx_o <= 3'd5));

  a_r3_idx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !err_o) |-> (err_idx_o == 3'd0));

  a_r9_value_legit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !uncorr_o) |-> (64'(value_o) < 64'(MLEG)));

  a_r7_value_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && uncorr_o) |-> (value_o == '0));

endmodule

bind rrns_corrector rrns_corrector_chk #(.N(N)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .valid_o   (valid_o),
  .value_o   (value_o),
  .err_o     (err_o),
  .err_idx_o (err_idx_o),
  .uncorr_o  (uncorr_o)
);

// File: tb/test_rrns_corrector.sv
`timescale 1ns/1ps
module test_rrns_corrector;

  localparam int N  = 2;
  localparam int VW = rrns_pkg::legit_width(N);
  localparam int ML = 60;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [N-1:0]    res1_i = '0;
  logic [N-1:0]    res2_i = '0;
  logic [N:0]      res3_i = '0;
  logic [2*N-1:0]  res4_i = '0;
  logic [2*N:0]    res5_i = '0;
  logic            valid_o;
  logic [VW-1:0]   value_o;
  logic [N-1:0]    fix1_o;
  logic [N-1:0]    fix2_o;
  logic [N:0]      fix3_o;
  logic [2*N-1:0]  fix4_o;
  logic [2*N:0]    fix5_o;
  logic            err_o;
  logic [2:0]      err_idx_o;
  logic            uncorr_o;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  rrns_corrector #(.N(N)) i_rrns_corrector (
    .clk_i, .rst_ni, .start_i, .res1_i, .res2_i, .res3_i, .res4_i, .res5_i,
    .valid_o, .value_o, .fix1_o, .fix2_o, .fix3_o, .fix4_o, .fix5_o,
    .err_o, .err_idx_o, .uncorr_o
  );

  function automatic int md(int j);
    case (j)
      0: return (1 << N) - 1;
      1: return (1 << N);
      2: return (1 << N) + 1;
      3: return (1 << (2 * N)) - 3;
      default: return (1 << (2 * N)) + 1;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // brute-force reference: search the legitimate range for matching integers
  task automatic model(input int r[5], output int e_err, output int e_unc,
                       output int e_idx, output int e_val, output int e_fix[5]);
    int found, cnt, y_hit, idx_hit;
    found = -1;
    for (int y = 0; y < ML; y++) begin
      bit ok = 1'b1;
      for (int j = 0; j < 5; j++) if (y % md(j) != r[j]) ok = 1'b0;
      if (ok) found = y;
    end
    e_fix = r;
    if (found >= 0) begin
      e_err = 0; e_unc = 0; e_idx = 0; e_val = found;
      return;
    end
    cnt = 0; y_hit = 0; idx_hit = 0;
    for (int i = 1; i <= 5; i++) begin
      for (int y = 0; y < ML; y++) begin
        bit ok = 1'b1;
        for (int j = 0; j < 5; j++)
          if (j != i - 1 && y % md(j) != r[j]) ok = 1'b0;
        if (ok) begin cnt++; y_hit = y; idx_hit = i; end
      end
    end
    if (cnt == 1) begin
      e_err = 1; e_unc = 0; e_idx = idx_hit; e_val = y_hit;
      for (int j = 0; j < 5; j++) e_fix[j] = y_hit % md(j);
    end else begin
      e_err = 0; e_unc = 1; e_idx = 0; e_val = 0;
    end
  endtask

  task automatic drive(int r[5]);
    res1_i = r[0][N-1:0];
    res2_i = r[1][N-1:0];
    res3_i = r[2][N:0];
    res4_i = r[3][2*N-1:0];
    res5_i = r[4][2*N:0];
  endtask

  task automatic run(int r[5], bit poke);
    int e_err, e_unc, e_idx, e_val, k;
    int e_fix[5];
    string rf, rv, rx;
    int junk[5];
    model(r, e_err, e_unc, e_idx, e_val, e_fix);
    rf = e_unc ? "R7" : (e_err ? "R4" : "R1/R3");
    rv = e_unc ? "R7" : (e_err ? "R5" : "R3");
    rx = e_unc ? "R7" : "R6";
    drive(r);
    start_i = 1'b1;
    k = 0;
    do begin
      @(posedge clk_i);
      k++;
      @(negedge clk_i);
      if (k == 1) start_i = 1'b0;
      if (poke && k == 3) begin
        for (int j = 0; j < 5; j++) junk[j] = (r[j] + 1) % md(j);
        drive(junk);
        start_i = 1'b1;
      end
      if (poke && k == 4) start_i = 1'b0;
    end while (!valid_o && k < 20);
    check("R2 latency", k, 7);
    check({rf, " err_o"}, int'(err_o), e_err);
    check({rf, " uncorr_o"}, int'(uncorr_o), e_unc);
    check({rf, " err_idx_o"}, int'(err_idx_o), e_idx);
    check({rv, " value_o"}, int'(value_o), e_val);
    check({rx, " fix1"}, int'(fix1_o), e_fix[0]);
    check({rx, " fix2"}, int'(fix2_o), e_fix[1]);
    check({rx, " fix3"}, int'(fix3_o), e_fix[2]);
    check({rx, " fix4"}, int'(fix4_o), e_fix[3]);
    check({rx, " fix5"}, int'(fix5_o), e_fix[4]);
    @(negedge clk_i);
    check("R2 pulse width", int'(valid_o), 0);
    if (poke) begin
      int extra = 0;
      repeat (10) begin
        @(negedge clk_i);
        if (valid_o) extra++;
      end
      check("R10 no extra valid", extra, 0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int r[5];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R8 reset state
    check("R8 valid_o", int'(valid_o), 0);
    check("R8 err_o", int'(err_o), 0);
    check("R8 uncorr_o", int'(uncorr_o), 0);
    check("R8 err_idx_o", int'(err_idx_o), 0);
    check("R8 value_o", int'(value_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // worked example: residue 2 corrupted to 3 in the codeword of 57
    r = '{0, 3, 2, 5, 6};
    run(r, 1'b0);

    // every integer, clean and with every single-residue corruption (R4, R5, R6)
    for (int x = 0; x < ML; x++) begin
      for (int j = 0; j < 5; j++) r[j] = x % md(j);
      run(r, 1'b0);
      for (int i = 0; i < 5; i++) begin
        for (int v = 0; v < md(i); v++) begin
          int c[5];
          c = r;
          if (v != r[i]) begin
            c[i] = v;
            run(c, 1'b0);
          end
        end
      end
    end

    // R10: restart attempt and input change mid-run
    for (int j = 0; j < 5; j++) r[j] = 41 % md(j);
    r[3] = (r[3] + 5) % md(3);
    run(r, 1'b1);
    for (int j = 0; j < 5; j++) r[j] = 7 % md(j);
    run(r, 1'b1);

    // random double corruptions, R7 expected for most
    repeat (300) begin
      int x, p, q;
      x = $urandom_range(ML - 1);
      p = $urandom_range(4);
      q = (p + 1 + $urandom_range(3)) % 5;
      for (int j = 0; j < 5; j++) r[j] = x % md(j);
      r[p] = (r[p] + 1 + $urandom_range(md(p) - 2)) % md(p);
      r[q] = (r[q] + 1 + $urandom_range(md(q) - 2)) % md(q);
      run(r, 1'b0);
    end

    finish_run();
  end

endmodule